// File: doc/BRIEF.md
# Banked Scratchpad Conflict Arbiter

The block takes one warp-wide scratchpad request of 32 lane word addresses, an active mask, a write flag and per-lane write data, and serves it from a scratchpad split into 32 banks. The bank of a word is its address modulo 32, and the row inside the bank is the rest of the address. When several lanes need different words of one bank, those words cannot be reached in the same cycle. The block therefore splits the request into conflict-free passes and reaches each bank at most once per pass. Lanes that want the same word share one access, so the block broadcasts a read word to every lane that asked for it. Several such shared words can be served in one pass, provided they sit in different banks.

The requester holds its request steady while `stall_o` is high. The cycle in which `stall_o` is low is the last pass. One cycle later `rvalid_o` pulses with the per-lane read data, and `pass_cnt_o` shows how many passes the request took. A request with no conflict finishes in the cycle in which it is presented. Each bank is modelled as a simple RAM inside the block.

Top module: `scp_conflict_arb`

## Requirements
- R1: A lane's bank is address bits [4:0] and its row is address bits [ADDR_W-1:5]. A word written at an address is returned by a later read of that address.
- R2: A request takes as many passes (clock cycles) as the largest number of distinct words that its active lanes map to any one bank, and at least one. `pass_cnt_o` reports that number along with `rvalid_o`. Lanes whose addresses have a stride of 33 words therefore finish in one pass.
- R3: Active reads of the same word are merged. When all lanes read one word, a single pass returns that word to every lane.
- R4: Distinct words in distinct banks are each broadcast to several lanes within the same pass.
- R5: `stall_o` is high during every pass of a request except the last, and low when `req_valid_i` is low.
- R6: `rvalid_o` pulses one cycle after the last pass. `rdata_o` then holds the stored word for every active read lane, and 0 for inactive lanes and for all lanes of a write request.
- R7: Within a bank, each pass serves the word requested by the lowest-numbered pending lane. When several active lanes write one word, the data of the highest-numbered of them is stored.
- R8: A request with an empty mask completes in one pass with `pass_cnt_o` = 1 and changes no stored word.
- R9: After reset, `stall_o`, `rvalid_o`, `pass_cnt_o` and `rdata_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present; held with its fields while stall_o is high |
| req_we_i | input | 1 | 1 = write request, 0 = read request |
| req_mask_i | input | LANES | Active lane mask |
| req_addr_i | input | LANES*ADDR_W | Word address per lane, lane 0 in the low bits |
| req_wdata_i | input | LANES*DATA_W | Write data per lane |
| stall_o | output | 1 | More passes remain after this cycle |
| rvalid_o | output | 1 | Request finished, rdata_o valid |
| rdata_o | output | LANES*DATA_W | Read data per lane |
| pass_cnt_o | output | CNT_W | Debug: number of passes taken by the last request |

## Verification
The bench drives lanes that all hit one bank with distinct rows, which needs 32 passes. A design that merged by bank instead of by word would finish early and return the same data to every lane. Full-warp broadcasts, stride-33 column patterns and mixed multi-word broadcasts are all expected to finish in one pass; a design that serialised same-word reads would report too many passes. Colliding writes check that the highest lane wins, and an empty mask checks that nothing is written. Random requests over a small address window pile up conflicts, and a bench model checks both the data and the pass counts.

// File: rtl/scp_pkg.sv
package scp_pkg;
  parameter int unsigned DEF_LANES  = 32;
  parameter int unsigned DEF_BANKS  = 32;
  parameter int unsigned DEF_ADDR_W = 10;
  parameter int unsigned DEF_DATA_W = 32;
endpackage

// File: rtl/scp_bank_ram.sv
module scp_bank_ram #(
  parameter int unsigned ROWS   = 32,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [ROWS];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[row_i] <= wdata_i;
  end

  assign rdata_o = mem_q[row_i];
endmodule

// File: rtl/scp_bank_pick.sv
module scp_bank_pick #(
  parameter int unsigned LANES   = 32,
  parameter int unsigned BANK_W  = 5,
  parameter int unsigned ADDR_W  = 10,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned BANK_ID = 0,
  localparam int unsigned ROW_W  = ADDR_W - BANK_W
) (
  input  logic [LANES-1:0]        pend_i,
  input  logic [LANES*ADDR_W-1:0] addr_i,
  input  logic [LANES*DATA_W-1:0] wdata_i,
  output logic                    active_o,
  output logic [ROW_W-1:0]        row_o,
  output logic [LANES-1:0]        match_o,
  output logic [DATA_W-1:0]       wdata_o
);
  logic [LANES-1:0] hit;

  always_comb begin
    hit   = '0;
    row_o = '0;
    for (int l = 0; l < LANES; l++)
      hit[l] = pend_i[l] && (addr_i[l*ADDR_W +: BANK_W] == BANK_W'(BANK_ID));
    // descending scan: lowest pending lane sets the row last
    for (int l = LANES-1; l >= 0; l--)
      if (hit[l]) row_o = addr_i[l*ADDR_W+BANK_W +: ROW_W];
  end

  assign active_o = |hit;

  always_comb begin
    match_o = '0;
    wdata_o = '0;
    for (int l = 0; l < LANES; l++) begin
      match_o[l] = hit[l] && (addr_i[l*ADDR_W+BANK_W +: ROW_W] == row_o);
      if (match_o[l]) wdata_o = wdata_i[l*DATA_W +: DATA_W]; // highest lane wins
    end
  end
endmodule

// File: rtl/scp_conflict_arb.sv
module scp_conflict_arb
  import scp_pkg::*;
#(
  parameter int unsigned LANES  = DEF_LANES,
  parameter int unsigned BANKS  = DEF_BANKS,
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter int unsigned DATA_W = DEF_DATA_W,
  localparam int unsigned BANK_W = $clog2(BANKS),
  localparam int unsigned ROW_W  = ADDR_W - BANK_W,
  localparam int unsigned ROWS   = 1 << ROW_W,
  localparam int unsigned CNT_W  = $clog2(LANES + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_valid_i,
  input  logic                    req_we_i,
  input  logic [LANES-1:0]        req_mask_i,
  input  logic [LANES*ADDR_W-1:0] req_addr_i,
  input  logic [LANES*DATA_W-1:0] req_wdata_i,
  output logic                    stall_o,
  output logic                    rvalid_o,
  output logic [LANES*DATA_W-1:0] rdata_o,
  output logic [CNT_W-1:0]        pass_cnt_o
);
  logic [LANES-1:0] done_q, pending, served;
  logic [CNT_W-1:0] pass_q;
  logic             busy_q;
  logic [LANES-1:0]  match_b [BANKS];
  logic [DATA_W-1:0] rd_b    [BANKS];

  assign pending = req_valid_i ? (req_mask_i & ~done_q) : '0;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic             act;
    logic [ROW_W-1:0] row;
    logic [DATA_W-1:0] wd;

    scp_bank_pick #(
      .LANES(LANES), .BANK_W(BANK_W), .ADDR_W(ADDR_W),
      .DATA_W(DATA_W), .BANK_ID(b)
    ) u_pick (
      .pend_i(pending), .addr_i(req_addr_i), .wdata_i(req_wdata_i),
      .active_o(act), .row_o(row), .match_o(match_b[b]), .wdata_o(wd)
    );

    scp_bank_ram #(.ROWS(ROWS), .DATA_W(DATA_W)) u_ram (
      .clk_i(clk_i), .we_i(act && req_we_i), .row_i(row),
      .wdata_i(wd), .rdata_o(rd_b[b])
    );
  end

  always_comb begin
    served = '0;
    for (int b = 0; b < BANKS; b++) served |= match_b[b];
  end

  assign stall_o = req_valid_i && |(pending & ~served);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q     <= '0;
      pass_q     <= '0;
      busy_q     <= 1'b0;
      rvalid_o   <= 1'b0;
      rdata_o    <= '0;
      pass_cnt_o <= '0;
    end else begin
      rvalid_o <= req_valid_i && !stall_o;
      if (req_valid_i) begin
        for (int l = 0; l < LANES; l++) begin
          if (served[l] && !req_we_i)
            rdata_o[l*DATA_W +: DATA_W] <= rd_b[req_addr_i[l*ADDR_W +: BANK_W]];
          else if (!busy_q)
            rdata_o[l*DATA_W +: DATA_W] <= '0;
        end
        if (stall_o) begin
          done_q <= done_q | served;
          pass_q <= pass_q + 1'b1;
          busy_q <= 1'b1;
        end else begin
          done_q     <= '0;
          pass_q     <= '0;
          busy_q     <= 1'b0;
          pass_cnt_o <= pass_q + 1'b1;
        end
      end
    end
  end

  a_r5_idle_no_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> !stall_o);

  a_r6_rvalid_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !stall_o |=> rvalid_o);

  a_r2_pass_progress: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && stall_o |=> done_q != '0);

  a_r2_pass_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> (pass_cnt_o >= 1) && (pass_cnt_o <= CNT_W'(LANES)));

  a_r7_served_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |-> (served & ~pending) == '0);

  a_r6_rvalid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o || $past(req_valid_i));
endmodule

// File: tb/scp_conflict_arb_test.sv
module scp_conflict_arb_test;
  localparam int CLK_PERIOD = 10;
  localparam int L = 32, AW = 10, DW = 32, CW = 6;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_we = 0;
  logic [L-1:0] req_mask = '0;
  logic [L*AW-1:0] req_addr = '0;
  logic [L*DW-1:0] req_wdata = '0;
  logic stall, rvalid;
  logic [L*DW-1:0] rdata;
  logic [CW-1:0] pass_cnt;

  int errors = 0, checks = 0;
  logic [DW-1:0] model [1 << AW];
  logic [AW-1:0] t_addr [L];
  logic [DW-1:0] t_data [L];

  always #(CLK_PERIOD/2) clk = ~clk;

  scp_conflict_arb uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_we_i(req_we),
    .req_mask_i(req_mask), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .stall_o(stall), .rvalid_o(rvalid), .rdata_o(rdata), .pass_cnt_o(pass_cnt)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_passes(input logic [L-1:0] m);
    int best = 0;
    for (int b = 0; b < 32; b++) begin
      int n = 0;
      for (int i = 0; i < L; i++) begin
        bit dup = 0;
        if (!m[i] || t_addr[i][4:0] != 5'(b)) continue;
        for (int j = 0; j < i; j++)
          if (m[j] && t_addr[j] == t_addr[i]) dup = 1;
        if (!dup) n++;
      end
      if (n > best) best = n;
    end
    return (best == 0) ? 1 : best;
  endfunction

  task automatic run(input bit we, input logic [L-1:0] m, input string tag);
    int cyc = 0, np;
    bit s, dok = 1;
    logic [DW-1:0] exp_d [L];
    np = exp_passes(m);
    for (int i = 0; i < L; i++) exp_d[i] = (!we && m[i]) ? model[t_addr[i]] : '0;
    if (we) for (int i = 0; i < L; i++) if (m[i]) model[t_addr[i]] = t_data[i];
    @(negedge clk);
    req_valid = 1; req_we = we; req_mask = m;
    for (int i = 0; i < L; i++) begin
      req_addr[i*AW +: AW] = t_addr[i];
      req_wdata[i*DW +: DW] = t_data[i];
    end
    forever begin
      #1 s = stall;
      @(posedge clk);
      cyc++;
      if (!s || cyc > 40) break;
      @(negedge clk);
    end
    #1;
    check(rvalid == 1'b1, {"R6 rvalid ", tag}, rvalid, 1);
    check(cyc == np, {"R2 R5 cycles ", tag}, cyc, np);
    check(pass_cnt == CW'(np), {"R2 pass_cnt ", tag}, pass_cnt, np);
    for (int i = 0; i < L; i++)
      if (rdata[i*DW +: DW] !== exp_d[i]) begin
        if (dok) check(0, {"R1 R6 rdata ", tag}, rdata[i*DW +: DW], exp_d[i]);
        dok = 0;
      end
    if (dok) check(1, "R6", 0, 0);
    @(negedge clk);
    req_valid = 0;
    #1 check(stall == 0, {"R5 idle ", tag}, stall, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #(CLK_PERIOD * 3);
    check(stall == 0 && rvalid == 0 && pass_cnt == 0 && rdata == '0, "R9 reset", rvalid, 0);
    rst_n = 1;
    // fill every word, conflict-free rows
    for (int r = 0; r < 32; r++) begin
      for (int i = 0; i < L; i++) begin t_addr[i] = AW'(r*32 + i); t_data[i] = $urandom; end
      run(1, '1, "fill");
    end
    // R3 full broadcast
    for (int i = 0; i < L; i++) t_addr[i] = AW'(77);
    run(0, '1, "R3 broadcast");
    // R2 stride 33 conflict-free
    for (int i = 0; i < L; i++) t_addr[i] = AW'(i*33);
    run(0, '1, "R2 stride33");
    // R2 worst case: one bank, 32 rows
    for (int i = 0; i < L; i++) t_addr[i] = AW'(i*32 + 5);
    run(0, '1, "R2 same bank");
    // R4 multi-word broadcast in one pass
    for (int i = 0; i < L; i++) t_addr[i] = AW'(100 + (i % 4));
    run(0, '1, "R4 multi broadcast");
    // R7 write collision, highest lane wins
    for (int i = 0; i < L; i++) begin t_addr[i] = AW'(300); t_data[i] = 32'hA000 + i; end
    run(1, 32'h0000_F0F1, "R7 write collide");
    for (int i = 0; i < L; i++) t_addr[i] = AW'(300);
    run(0, 32'h1, "R7 readback");
    check(rdata[DW-1:0] == 32'hA000 + 15, "R7 winner", rdata[DW-1:0], 32'hA00F);
    // R7 mixed rows in a bank with partial mask
    for (int i = 0; i < L; i++) t_addr[i] = (i < 3) ? AW'(i*32 + 9) : AW'(9);
    run(0, 32'h0000_00FF, "R7 mixed");
    // R8 empty mask writes nothing
    for (int i = 0; i < L; i++) begin t_addr[i] = AW'(400 + i); t_data[i] = 32'hDEAD; end
    run(1, '0, "R8 empty");
    run(0, '1, "R8 readback");
    // random
    for (int k = 0; k < 60; k++) begin
      bit we = ($urandom_range(0, 3) == 0);
      int span = ($urandom_range(0, 1) == 0) ? 96 : 1023;
      for (int i = 0; i < L; i++) begin t_addr[i] = AW'($urandom_range(0, span)); t_data[i] = $urandom; end
      run(we, $urandom, "random");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule